// File: doc/BRIEF.md
# Disk Controller Command and Result Sequencer

This block is the host-side register front end of a floppy-style disk controller. The host sends a command as a run of bytes through one data port and collects the answer through the same port. A status byte tells the host when the port is ready and in which direction the next byte flows. The first byte of each command is an opcode. From the opcode the block knows how many parameter bytes to accept and how many result bytes to offer. A control byte holds the controller in soft reset and also drives the drive-select and motor lines.

The drive mechanism is modelled by behaviour alone. There is one head position shared by all units. A seek or recalibrate runs in the background for `SEEK_CYCLES` cycles and then raises an interrupt. A sector read or write holds the block in an execution phase for `XFER_CYCLES` cycles and then moves to a seven-byte result phase. No sector data is stored.

The host selects a register with `sel`:
- 0 is the control byte.
- 1 is the status byte.
- 2 is the data port.

Top module: `fdc_seq`

## Requirements
- R1: The status byte (sel=1) has the following layout:
  - Bit 7 is ready.
  - Bit 6 is set when a byte waits for the host.
  - Bit 5 is set during read/write execution when non-DMA mode is on.
  - Bit 4 is set while a command is between its opcode and its last result byte.
  - Bits 3:0 have a one-hot bit for the unit whose seek is in progress.
  - The whole byte reads 0x00 while control bit 2 is low.
- R2: A data-port write is taken only when status bits 7:6 are 10. A data-port read is taken only when they are 11. Any other access changes nothing, and a read outside the result phase returns 0x00.
- R3: Opcode 0x10 takes no parameters and returns one byte, 0x90.
- R4: Opcode 0x08 takes no parameters. It returns two bytes: the latched status-0, then the current cylinder. Reading the second byte clears the pending interrupt.
- R5: Opcode 0x0F takes a unit byte (head in bit 2, unit in bits 1:0) and then a cylinder byte, and returns no bytes. Exactly `SEEK_CYCLES` cycles after the last byte, the following happen:
  - The cylinder takes the target value.
  - Status-0 latches 0x20 OR the low three bits of the unit byte.
  - An interrupt becomes pending.
- R6: Opcode 0x07 takes one unit byte and behaves like a seek whose target is cylinder 0.
- R7: Opcode 0x03 takes two bytes and returns nothing. Bit 0 of the second byte turns on non-DMA mode, which then shows in status bit 5 during execution.
- R8: Opcode 0x04 takes one byte (head in bit 2, unit in bits 1:0) and returns one byte with this layout:
  - Bit 5 is 1.
  - Bit 4 is set when the cylinder is 0.
  - Bits 2:0 echo the head and unit.
  - All other bits are 0.
- R9: Opcodes 0x46 and 0xC5 take eight bytes in this order: head/unit, cylinder, head, sector, size, end-of-track, gap, length. Status then reads ready=0 for `XFER_CYCLES` cycles. After that an interrupt becomes pending and seven bytes follow. When sector is not equal to end-of-track, the bytes are:
  - the head/unit bits
  - 0x00
  - 0x00
  - cylinder
  - head
  - sector+1
  - size
- R10: When sector equals end-of-track, the seven result bytes are:
  - 0x40 OR the head/unit bits
  - 0x80
  - 0x00
  - cylinder+1
  - head
  - 0x01
  - size
- R11: Reading the seventh result byte of a read or write clears the pending interrupt.
- R12: Any other opcode returns one byte, 0x80, at once.
- R13: The control byte (sel=0) behaves as follows:
  - It reads back as written.
  - `motor_o` is bits 7:4 and `dsel_o` is bits 1:0.
  - `irq_o` is the pending interrupt gated by bit 3.
  - A write with bit 2 low clears the command state, the seek, the cylinder and the pending interrupt.
  - A write that takes bit 2 from 0 to 1 makes an interrupt pending with status-0 equal to 0xC0.
- R14: If a seek completes in the same cycle that an interrupt-clearing read is taken, the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; pops a result byte when the data port is selected |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| motor_o | output | 4 | Per-drive motor enables |
| dsel_o | output | 2 | Selected drive |

## Verification
A background seek can reach its end in the same cycle as a host read that would clear the interrupt. This applies to the last byte of a sense-interrupt answer or of a transfer result. The bench leaves an interrupt pending from a recalibrate. It then starts a seek and issues a sense-interrupt command, spacing the idle cycles so that the second result byte is read exactly at the seek's completion edge. The bytes read must be the state snapshotted when the sense command started. The interrupt must remain asserted afterwards, and a further sense command must report the new seek.

// File: rtl/fdc_seq.sv
module fdc_seq #(
  parameter int SEEK_CYCLES = 12,
  parameter int XFER_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_o,
  output logic [3:0] motor_o,
  output logic [1:0] dsel_o
);
  localparam int TMAX = (SEEK_CYCLES > XFER_CYCLES) ? SEEK_CYCLES : XFER_CYCLES;
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [7:0] OP_VER = 8'h10, OP_SNS = 8'h08, OP_SEEK = 8'h0F, OP_RCL = 8'h07;
  localparam logic [7:0] OP_SPEC = 8'h03, OP_DRV = 8'h04, OP_RD = 8'h46, OP_WR = 8'hC5;
  localparam logic [1:0] PH_CMD = 2'd0, PH_PRM = 2'd1, PH_EXE = 2'd2, PH_RES = 2'd3;

  function automatic logic [3:0] nparm(input logic [7:0] o);
    case (o)
      OP_SPEC, OP_SEEK: nparm = 4'd2;
      OP_DRV, OP_RCL:   nparm = 4'd1;
      OP_RD, OP_WR:     nparm = 4'd8;
      default:          nparm = 4'd0;
    endcase
  endfunction

  logic [7:0] ctl, op, cyl, st0, tgt;
  logic [1:0] ph;
  logic [2:0] shu, ridx, rlen;
  logic [3:0] pidx;
  logic [7:0] prm [8];
  logic [7:0] res [8];
  logic [TW-1:0] scnt, xcnt;
  logic ipend, nd;

  wire run    = ctl[2];
  wire ctl_wr = wr_en && sel == 2'd0;
  wire hold   = !run || (ctl_wr && !wdata[2]);
  wire rel    = ctl_wr && wdata[2] && !run;
  wire wr_acc = wr_en && sel == 2'd2 && run && (ph == PH_CMD || ph == PH_PRM);
  wire rd_acc = rd_en && sel == 2'd2 && run && ph == PH_RES;
  wire rd_last = rd_acc && ridx == rlen - 3'd1;
  wire rw_op  = op == OP_RD || op == OP_WR;
  wire [7:0] oc = (ph == PH_CMD) ? wdata : op;
  wire [3:0] need = nparm(oc);
  wire launch = wr_acc && ((ph == PH_CMD) ? need == 4'd0 : pidx == need - 4'd1);
  wire [7:0] pv0 = (ph == PH_PRM && pidx == 4'd0) ? wdata : prm[0];
  wire [7:0] pv1 = (ph == PH_PRM && pidx == 4'd1) ? wdata : prm[1];
  wire seek_done = scnt == TW'(1);
  wire xfer_done = ph == PH_EXE && xcnt == TW'(1);
  wire eoc = prm[3] == prm[5];
  wire [7:0] msr = {ph != PH_EXE, ph == PH_RES, ph == PH_EXE && nd, ph != PH_CMD,
                    (scnt != '0) ? (4'b0001 << shu[1:0]) : 4'b0000};

  assign rdata   = (sel == 2'd0) ? ctl :
                   (sel == 2'd1) ? (run ? msr : 8'h00) :
                   (sel == 2'd2 && ph == PH_RES) ? res[ridx] : 8'h00;
  assign irq_o   = ipend & ctl[3];
  assign motor_o = ctl[7:4];
  assign dsel_o  = ctl[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; op <= '0; cyl <= '0; st0 <= '0; tgt <= '0; ph <= PH_CMD;
      shu <= '0; ridx <= '0; rlen <= 3'd1; pidx <= '0; scnt <= '0; xcnt <= '0;
      ipend <= 1'b0; nd <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= wdata;
      if (hold) begin
        op <= '0; cyl <= '0; tgt <= '0; ph <= PH_CMD; shu <= '0; ridx <= '0;
        rlen <= 3'd1; pidx <= '0; scnt <= '0; xcnt <= '0; nd <= 1'b0;
        ipend <= rel;
        st0 <= rel ? 8'hC0 : 8'h00;
      end else begin
        if (scnt != '0) scnt <= scnt - TW'(1);
        if (seek_done) begin
          cyl <= tgt;
          st0 <= 8'h20 | {5'b0, shu};
        end
        if (ph == PH_EXE) begin
          xcnt <= xcnt - TW'(1);
          if (xfer_done) begin
            res[0] <= eoc ? {2'b01, 3'b0, prm[0][2:0]} : {5'b0, prm[0][2:0]};
            res[1] <= eoc ? 8'h80 : 8'h00;
            res[2] <= 8'h00;
            res[3] <= prm[1] + (eoc ? 8'd1 : 8'd0);
            res[4] <= prm[2];
            res[5] <= eoc ? 8'd1 : prm[3] + 8'd1;
            res[6] <= prm[4];
            ph <= PH_RES; ridx <= '0; rlen <= 3'd7;
          end
        end
        if (rd_acc) begin
          if (rd_last) ph <= PH_CMD;
          else ridx <= ridx + 3'd1;
        end
        if (wr_acc) begin
          if (ph == PH_CMD) begin
            op <= wdata; pidx <= '0;
            if (need != 4'd0) ph <= PH_PRM;
          end else begin
            prm[pidx[2:0]] <= wdata;
            pidx <= pidx + 4'd1;
          end
          if (launch) begin
            ridx <= '0;
            case (oc)
              OP_VER:  begin res[0] <= 8'h90; rlen <= 3'd1; ph <= PH_RES; end
              OP_SNS:  begin res[0] <= st0; res[1] <= cyl; rlen <= 3'd2; ph <= PH_RES; end
              OP_DRV:  begin
                res[0] <= {2'b00, 1'b1, cyl == 8'd0, 1'b0, pv0[2:0]};
                rlen <= 3'd1; ph <= PH_RES;
              end
              OP_SPEC: begin nd <= pv1[0]; ph <= PH_CMD; end
              OP_SEEK, OP_RCL: begin
                scnt <= TW'(SEEK_CYCLES);
                tgt <= (oc == OP_SEEK) ? pv1 : 8'h00;
                shu <= pv0[2:0];
                ph <= PH_CMD;
              end
              OP_RD, OP_WR: begin xcnt <= TW'(XFER_CYCLES); ph <= PH_EXE; end
              default: begin res[0] <= 8'h80; rlen <= 3'd1; ph <= PH_RES; end
            endcase
          end
        end
        if (seek_done || xfer_done) ipend <= 1'b1;
        else if (rd_last && (op == OP_SNS || rw_op)) ipend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fdc_seq_chk.sv
module fdc_seq_chk #(
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          run,
  input logic [1:0]    ph,
  input logic [TW-1:0] scnt,
  input logic [TW-1:0] xcnt,
  input logic          ipend,
  input logic [7:0]    cyl,
  input logic [7:0]    tgt,
  input logic [1:0]    sel,
  input logic [7:0]    rdata
);
  a_r13_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (ph == 2'd0 && scnt == '0 && xcnt == '0));

  a_r5_seek_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && scnt == TW'(1)) |=> (ipend && cyl == $past(tgt)));

  a_r9_exec_to_result: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && ph == 2'd2 && xcnt == TW'(1)) |=> (ph == 2'd3 && ipend));

  a_r9_exec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && ph == 2'd2 && xcnt > TW'(1)) |=> ph == 2'd2);

  a_r1_dir_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel == 2'd1 && rdata[6]) |-> rdata[7]);
endmodule

bind fdc_seq fdc_seq_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hold(hold), .run(run), .ph(ph), .scnt(scnt),
  .xcnt(xcnt), .ipend(ipend), .cyl(cyl), .tgt(tgt), .sel(sel), .rdata(rdata)
);

// File: tb/fdc_seq_tb_top.sv
module fdc_seq_tb_top;
  localparam int SC = 12;
  localparam int XC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  wire [7:0] rdata;
  wire irq_o;
  wire [3:0] motor_o;
  wire [1:0] dsel_o;

  always #5 clk = ~clk;

  fdc_seq #(.SEEK_CYCLES(SC), .XFER_CYCLES(XC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .motor_o(motor_o), .dsel_o(dsel_o)
  );

  int checks = 0, errors = 0;

  logic [7:0] m_ctl, m_op, m_cyl, m_st0, m_tgt;
  logic [2:0] m_shu;
  int m_ph, m_scnt, m_xcnt;
  bit m_int, m_nd;
  logic [7:0] m_p[$];
  logic [7:0] m_r[$];

  function automatic int need_of(input logic [7:0] o);
    if (o == 8'h03 || o == 8'h0F) return 2;
    if (o == 8'h04 || o == 8'h07) return 1;
    if (o == 8'h46 || o == 8'hC5) return 8;
    return 0;
  endfunction

  function automatic logic [7:0] m_rdata(input logic [1:0] s);
    if (s == 2'd0) return m_ctl;
    if (s == 2'd1) begin
      if (!m_ctl[2]) return 8'h00;
      return {m_ph != 2, m_ph == 3, m_ph == 2 && m_nd, m_ph != 0,
              (m_scnt != 0) ? (4'b0001 << m_shu[1:0]) : 4'b0000};
    end
    if (s == 2'd2 && m_ph == 3 && m_r.size() > 0) return m_r[0];
    return 8'h00;
  endfunction

  task automatic model_clear();
    m_op = 0; m_cyl = 0; m_st0 = 0; m_tgt = 0; m_shu = 0; m_ph = 0;
    m_scnt = 0; m_xcnt = 0; m_int = 0; m_nd = 0; m_p.delete(); m_r.delete();
  endtask

  task automatic m_launch(input logic [7:0] ocyl, input logic [7:0] ost0);
    m_r.delete();
    case (m_op)
      8'h10: begin m_r.push_back(8'h90); m_ph = 3; end
      8'h08: begin m_r.push_back(ost0); m_r.push_back(ocyl); m_ph = 3; end
      8'h04: begin m_r.push_back({2'b00, 1'b1, ocyl == 8'd0, 1'b0, m_p[0][2:0]}); m_ph = 3; end
      8'h03: begin m_nd = m_p[1][0]; m_ph = 0; end
      8'h0F: begin m_scnt = SC; m_tgt = m_p[1]; m_shu = m_p[0][2:0]; m_ph = 0; end
      8'h07: begin m_scnt = SC; m_tgt = 0; m_shu = m_p[0][2:0]; m_ph = 0; end
      8'h46, 8'hC5: begin m_xcnt = XC; m_ph = 2; end
      default: begin m_r.push_back(8'h80); m_ph = 3; end
    endcase
  endtask

  task automatic model_edge(input logic [1:0] s, input bit w, input bit r, input logic [7:0] d);
    bit cw, run, hold, rel, dw, dr, iset, iclr, eoc;
    logic [7:0] ocyl, ost0;
    cw = w && s == 0; run = m_ctl[2];
    hold = !run || (cw && !d[2]); rel = cw && d[2] && !run;
    dw = w && s == 2 && run && (m_ph == 0 || m_ph == 1);
    dr = r && s == 2 && run && m_ph == 3;
    ocyl = m_cyl; ost0 = m_st0; iset = 0; iclr = 0;
    if (cw) m_ctl = d;
    if (hold) begin
      model_clear();
      m_int = rel;
      if (rel) m_st0 = 8'hC0;
      return;
    end
    if (m_scnt > 0) begin
      if (m_scnt == 1) begin m_cyl = m_tgt; m_st0 = 8'h20 | {5'b0, m_shu}; iset = 1; end
      m_scnt--;
    end
    if (m_ph == 2) begin
      if (m_xcnt == 1) begin
        eoc = m_p[3] == m_p[5];
        m_r.delete();
        m_r.push_back(eoc ? (8'h40 | {5'b0, m_p[0][2:0]}) : {5'b0, m_p[0][2:0]});
        m_r.push_back(eoc ? 8'h80 : 8'h00);
        m_r.push_back(8'h00);
        m_r.push_back(eoc ? m_p[1] + 8'd1 : m_p[1]);
        m_r.push_back(m_p[2]);
        m_r.push_back(eoc ? 8'd1 : m_p[3] + 8'd1);
        m_r.push_back(m_p[4]);
        m_ph = 3; iset = 1;
      end
      m_xcnt--;
    end
    if (dr) begin
      void'(m_r.pop_front());
      if (m_r.size() == 0) begin
        m_ph = 0;
        if (m_op == 8'h08 || m_op == 8'h46 || m_op == 8'hC5) iclr = 1;
      end
    end
    if (dw) begin
      if (m_ph == 0) begin
        m_op = d; m_p.delete();
        if (need_of(d) > 0) m_ph = 1; else m_launch(ocyl, ost0);
      end else begin
        m_p.push_back(d);
        if (m_p.size() == need_of(m_op)) m_launch(ocyl, ost0);
      end
    end
    if (iset) m_int = 1; else if (iclr) m_int = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [1:0] s, input bit w, input bit r, input logic [7:0] d,
                     input string tag, input bit he, input logic [7:0] ex);
    sel = s; wr_en = w; rd_en = r; wdata = d;
    #1;
    if (he) chk(tag, rdata, ex);
    chk({tag, " model rdata"}, rdata, m_rdata(s));
    chk({tag, " model pins"}, {1'b0, motor_o, dsel_o, irq_o},
        {1'b0, m_ctl[7:4], m_ctl[1:0], m_int & m_ctl[3]});
    @(posedge clk);
    model_edge(s, w, r, d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wrb(input logic [7:0] d, input string tag); cyc(2, 1, 0, d, tag, 0, 0); endtask
  task automatic rdb(input logic [7:0] e, input string tag); cyc(2, 0, 1, 0, tag, 1, e); endtask
  task automatic msr(input logic [7:0] e, input string tag); cyc(1, 0, 0, 0, tag, 1, e); endtask
  task automatic ctlw(input logic [7:0] d, input string tag); cyc(0, 1, 0, d, tag, 0, 0); endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(3, 0, 0, 0, tag, 0, 0);
  endtask
  task automatic irq_is(input bit e, input string tag);
    chk(tag, {7'b0, irq_o}, {7'b0, e});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    m_ctl = 0; model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    msr(8'h00, "R1 status in soft reset");
    irq_is(0, "R13 no irq after reset");

    ctlw(8'h1D, "R13 release");
    irq_is(1, "R13 release raises irq");
    chk("R13 motor", {4'b0, motor_o}, 8'h01);
    chk("R13 dsel", {6'b0, dsel_o}, 8'h01);
    cyc(0, 0, 0, 0, "R13 ctl readback", 1, 8'h1D);
    msr(8'h80, "R1 idle status");

    wrb(8'h08, "R4 sense op");
    msr(8'hD0, "R1 result status");
    rdb(8'hC0, "R4 st0 after release");
    rdb(8'h00, "R4 cylinder");
    irq_is(0, "R4 irq cleared");

    wrb(8'h10, "R3 version op");
    rdb(8'h90, "R3 version byte");
    msr(8'h80, "R3 back to idle");

    rdb(8'h00, "R2 read outside result");
    msr(8'h80, "R2 status unchanged");
    wrb(8'h10, "R2 version op");
    wrb(8'h08, "R2 write during result ignored");
    rdb(8'h90, "R2 result intact");
    msr(8'h80, "R2 idle after result");

    wrb(8'h03, "R7 specify"); wrb(8'hDF, "R7 p1"); wrb(8'h03, "R7 p2 nd on");
    msr(8'h80, "R7 no result");

    wrb(8'h0F, "R5 seek"); wrb(8'h01, "R5 unit"); wrb(8'h25, "R5 cyl");
    msr(8'h82, "R5 unit1 busy");
    idle(SC, "R5 wait");
    irq_is(1, "R5 seek irq");
    msr(8'h80, "R5 busy gone");
    wrb(8'h08, "R5 sense");
    rdb(8'h21, "R5 st0 seek end");
    rdb(8'h25, "R5 new cylinder");
    irq_is(0, "R4 irq cleared after seek sense");

    wrb(8'h04, "R8 drive status"); wrb(8'h05, "R8 hu");
    rdb(8'h25, "R8 not track0");

    wrb(8'h07, "R6 recal"); wrb(8'h00, "R6 unit");
    idle(SC, "R6 wait");
    irq_is(1, "R6 recal irq");
    wrb(8'h04, "R8 drive status 2"); wrb(8'h00, "R8 hu 2");
    rdb(8'h30, "R8 track0 after R6");

    wrb(8'h0F, "R14 seek"); wrb(8'h02, "R14 unit"); wrb(8'h40, "R14 cyl");
    wrb(8'h08, "R14 sense");
    idle(SC - 3, "R14 align");
    rdb(8'h20, "R14 old st0");
    rdb(8'h00, "R14 old cyl at completion edge");
    irq_is(1, "R14 irq kept by seek end");
    wrb(8'h08, "R14 sense again");
    rdb(8'h22, "R14 new st0");
    rdb(8'h40, "R14 new cyl");
    irq_is(0, "R14 cleared");

    wrb(8'h46, "R9 read op");
    wrb(8'h04, "R9 hu"); wrb(8'h00, "R9 c"); wrb(8'h01, "R9 h"); wrb(8'h03, "R9 r");
    wrb(8'h02, "R9 n"); wrb(8'h12, "R9 eot"); wrb(8'h1B, "R9 gap"); wrb(8'hFF, "R9 dtl");
    msr(8'h30, "R7 non-DMA exec status");
    wrb(8'h10, "R2 write during exec ignored");
    idle(XC - 3, "R9 exec");
    msr(8'h30, "R9 still executing");
    idle(1, "R9 exec end");
    irq_is(1, "R9 exec irq");
    msr(8'hD0, "R9 result status");
    rdb(8'h04, "R9 st0"); rdb(8'h00, "R9 st1"); rdb(8'h00, "R9 st2");
    rdb(8'h00, "R9 c"); rdb(8'h01, "R9 h"); rdb(8'h04, "R9 r"); rdb(8'h02, "R9 n");
    irq_is(0, "R11 cleared after last byte");
    msr(8'h80, "R9 idle");

    wrb(8'hC5, "R10 write op");
    wrb(8'h01, "R10 hu"); wrb(8'h05, "R10 c"); wrb(8'h00, "R10 h"); wrb(8'h12, "R10 r");
    wrb(8'h02, "R10 n"); wrb(8'h12, "R10 eot"); wrb(8'h1B, "R10 gap"); wrb(8'hFF, "R10 dtl");
    idle(XC, "R10 exec");
    rdb(8'h41, "R10 st0"); rdb(8'h80, "R10 st1 end of cyl"); rdb(8'h00, "R10 st2");
    rdb(8'h06, "R10 c+1"); rdb(8'h00, "R10 h"); rdb(8'h01, "R10 r wraps");
    irq_is(1, "R11 pending before last byte");
    rdb(8'h02, "R10 n");
    irq_is(0, "R11 cleared");

    wrb(8'h55, "R12 bad op");
    msr(8'hD0, "R12 result status");
    rdb(8'h80, "R12 invalid byte");
    msr(8'h80, "R12 idle");

    wrb(8'h0F, "R13 seek"); wrb(8'h00, "R13 unit"); wrb(8'h10, "R13 cyl");
    ctlw(8'h19, "R13 soft reset");
    msr(8'h00, "R13 status in reset");
    irq_is(0, "R13 irq dropped");
    idle(SC, "R13 hold");
    irq_is(0, "R13 seek cancelled");
    cyc(0, 0, 0, 0, "R13 ctl readback 2", 1, 8'h19);
    ctlw(8'h1D, "R13 release again");
    irq_is(1, "R13 release irq");
    wrb(8'h08, "R13 sense");
    rdb(8'hC0, "R13 st0");
    rdb(8'h00, "R13 cyl cleared");
    irq_is(0, "R13 clear");

    finish_run();
  end
endmodule